// File: doc/BRIEF.md
# Trigger-Matching Hit Buffer for a Multi-Channel TDC

This block collects digitized hit times from several time-to-digital converter channels and turns them into event frames. A channel writes into storage only in cycles where it reports a hit. Each channel has a small derandomizer queue. A round-robin merger moves one hit per clock from these queues into a shared common buffer. Each hit time is a 21-bit word. Its upper 11 bits are the coarse count; the lower 10 bits are already-interpolated fine time and are carried through untouched.

In triggered mode, each trigger time tag goes into a queue. The block subtracts a programmed latency from the tag to get a window start. Before matching, it discards hits at the head of the common buffer that are older than that start. It then scans the rest of the buffer without consuming it, so a hit can appear in the output of several overlapping triggers. Each event is sent out as a header, the matching hits and a trailer. In non-triggered mode, every buffered hit is sent out as a data word, in the order it arrived.

If a derandomizer queue is full, the new hit is dropped and a sticky error bit is set. The next trailer reports that bit. Frames are never truncated: a full output queue stalls the matcher instead.

Top module: `tdc_hit_buffer`

## Requirements
- R1: After reset, `out_valid` is low and stays low until a hit or trigger is supplied.
- R2: Storage is data-driven. An idle channel writes nothing, and no output word appears without a stored hit or a trigger.
- R3: With `mode_trig` low, every accepted hit is output once, in arrival order, as a data word. The data word is bits[25:24]=2'b10, bits[23:21]=channel and bits[20:0]=hit time.
- R4: With `mode_trig` high, every trigger yields one header word. The header is bits[25:24]=2'b01, bits[23:12]=0 and bits[11:0]=an event counter that starts at 0 after reset and rises by one per trigger, modulo 4096.
- R5: A buffered hit belongs to a trigger exactly when ((hit coarse bits[20:10]) − (tag − latency)) mod 2048 < `win_len`.
- R6: Triggers are served in order. Overlapping windows each receive every matching hit, so one hit can be output in several events.
- R7: Every event ends with a trailer word: bits[25:24]=2'b11, bit[12]=error flag, bits[11:0]=number of data words in that event. This includes events with no hits.
- R8: When a hit arrives at a full derandomizer queue, the hit is lost. The error flag is set and reported in the next trailer, then cleared.
- R9: Window matching works across coarse-count rollover from 2047 to 0.
- R10: When a trigger is processed, head hits whose coarse time is earlier than the window start (11-bit signed difference negative) are discarded. They do not appear in that event or in any later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_trig | input | 1 | 1 = trigger matching, 0 = pass every hit |
| latency | input | 11 | Subtracted from each trigger tag |
| win_len | input | 11 | Window length in coarse bins |
| hit_valid | input | NCH | Per-channel hit strobe |
| hit_time | input | NCH*21 | Per-channel hit time, channel c at bits [21c+20:21c] |
| trig_valid | input | 1 | Trigger strobe |
| trig_tag | input | 11 | Trigger coarse time tag |
| out_valid | output | 1 | Output word present (consumed the same cycle) |
| out_word | output | 26 | Header, data or trailer word |

## Verification
The checks assume the following about the inputs:
- A trigger never arrives while the trigger queue is full.
- `mode_trig`, `latency` and `win_len` are held steady while an event is in progress.
- Every hit belonging to a window reaches the common buffer before that trigger's scan starts.

The stimulus meets these conditions by working in phases. It injects hits, leaves idle gaps long enough for the merger to settle, then issues triggers. It changes the window only after all pending frames have been emitted. Within each phase hit times rise in window order, so discarding older head entries removes only hits that no later trigger needs.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
   localparam int TIME_W   = 21;
   localparam int COARSE_W = 11;
   localparam int EVCNT_W  = 12;

   typedef enum logic [1:0] {
      WT_NONE = 2'b00,
      WT_HDR  = 2'b01,
      WT_DATA = 2'b10,
      WT_TRL  = 2'b11
   } word_type_e;
endpackage

// File: rtl/tdc_fifo.sv
module tdc_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if ((1 << AW) != DEPTH) begin : g_depth_chk
      $error("tdc_fifo DEPTH must be a power of two");
   end

   logic [W-1:0] mem_q [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [AW:0]   cnt_q;
   logic          push_ok, pop_ok;

   assign full    = (cnt_q == (AW+1)'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem_q[rp_q];

   always_ff @(posedge clk) begin
      if (push_ok) mem_q[wp_q] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wp_q <= wp_q + 1'b1;
         if (pop_ok)  rp_q <= rp_q + 1'b1;
         cnt_q <= cnt_q + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
      end
   end

   // R2
   fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full) |=> !empty);
endmodule

// File: rtl/tdc_merge.sv
module tdc_merge #(
   parameter int NCH    = 8,
   parameter int TW     = 21,
   parameter int DDEPTH = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NCH-1:0]          hit_valid,
   input  logic [NCH*TW-1:0]       hit_time,
   input  logic                    dst_full,
   output logic                    m_valid,
   output logic [$clog2(NCH)-1:0]  m_ch,
   output logic [TW-1:0]           m_time,
   output logic                    drop
);
   localparam int CHW = $clog2(NCH);

   logic [NCH-1:0] grant, full_v, empty_v;
   logic [TW-1:0]  dq [NCH];
   logic [CHW-1:0] last_q, sel;
   logic           found;
   int             idx;

   for (genvar c = 0; c < NCH; c++) begin : g_derand
      tdc_fifo #(.W(TW), .DEPTH(DDEPTH)) u_q (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (hit_valid[c]),
         .din   (hit_time[c*TW +: TW]),
         .pop   (grant[c]),
         .dout  (dq[c]),
         .full  (full_v[c]),
         .empty (empty_v[c])
      );
   end

   always_comb begin
      sel   = '0;
      found = 1'b0;
      idx   = 0;
      for (int k = 1; k <= NCH; k++) begin
         idx = (int'(last_q) + k) % NCH;
         if (!found && !empty_v[idx]) begin
            found = 1'b1;
            sel   = CHW'(idx);
         end
      end
   end

   assign m_valid = found && !dst_full;
   assign grant   = m_valid ? (NCH'(1) << sel) : '0;
   assign m_ch    = sel;
   assign m_time  = dq[sel];
   assign drop    = |(hit_valid & full_v);

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= CHW'(NCH - 1);
      else if (m_valid) last_q <= sel;
   end

   // R2
   merge_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((~empty_v != '0) && !dst_full) |-> m_valid);
endmodule

// File: rtl/tdc_match.sv
module tdc_match
   import tdc_pkg::*;
#(
   parameter int NCH    = 8,
   parameter int TW     = 21,
   parameter int CW     = 11,
   parameter int CDEPTH = 16,
   parameter int TDEPTH = 4,
   parameter int OW     = 26
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   mode_trig,
   input  logic [CW-1:0]          latency,
   input  logic [CW-1:0]          win_len,
   input  logic                   in_valid,
   input  logic [$clog2(NCH)-1:0] in_ch,
   input  logic [TW-1:0]          in_time,
   input  logic                   drop,
   input  logic                   trig_valid,
   input  logic [CW-1:0]          trig_tag,
   input  logic                   o_full,
   output logic                   full,
   output logic                   o_push,
   output logic [OW-1:0]          o_word
);
   localparam int CHW = $clog2(NCH);
   localparam int EW  = CHW + TW;
   localparam int AW  = $clog2(CDEPTH);

   if ((1 << AW) != CDEPTH) begin : g_cdepth_chk
      $error("tdc_match CDEPTH must be a power of two");
   end
   if (OW != EW + 2 || OW < EVCNT_W + 3) begin : g_ow_chk
      $error("tdc_match OW does not fit the word formats");
   end

   typedef enum logic [2:0] {S_IDLE, S_HDR, S_PURGE, S_SCAN, S_TRL} state_e;

   state_e              state_q;
   logic [EW-1:0]       mem_q [CDEPTH];
   logic [AW:0]         wp_q, hp_q, sp_q;
   logic [CW-1:0]       start_q;
   logic [EVCNT_W-1:0]  cnt_q, evcnt_q;
   logic                err_q;

   logic                tq_pop, tq_full, tq_empty;
   logic [CW-1:0]       tq_tag;
   logic [EW-1:0]       head_e, scan_e;
   logic [CW-1:0]       d_head, d_scan;
   logic                head_old, scan_in, buf_any, scan_end;

   tdc_fifo #(.W(CW), .DEPTH(TDEPTH)) u_trigq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (trig_valid),
      .din   (trig_tag),
      .pop   (tq_pop),
      .dout  (tq_tag),
      .full  (tq_full),
      .empty (tq_empty)
   );

   assign full     = ((wp_q - hp_q) == (AW+1)'(CDEPTH));
   assign buf_any  = (wp_q != hp_q);
   assign scan_end = (sp_q == wp_q);
   assign head_e   = mem_q[hp_q[AW-1:0]];
   assign scan_e   = mem_q[sp_q[AW-1:0]];
   assign d_head   = head_e[TW-1 -: CW] - start_q;
   assign d_scan   = scan_e[TW-1 -: CW] - start_q;
   assign head_old = d_head[CW-1];
   assign scan_in  = (d_scan < win_len);

   always_comb begin
      o_push = 1'b0;
      o_word = '0;
      tq_pop = 1'b0;
      case (state_q)
         S_IDLE: if (!mode_trig && buf_any && !o_full) begin
            o_push = 1'b1;
            o_word = {WT_DATA, head_e};
         end
         S_HDR: if (!o_full) begin
            o_push = 1'b1;
            o_word = {WT_HDR, {(OW-2-EVCNT_W){1'b0}}, evcnt_q};
         end
         S_SCAN: if (!scan_end && scan_in && !o_full) begin
            o_push = 1'b1;
            o_word = {WT_DATA, scan_e};
         end
         S_TRL: if (!o_full) begin
            o_push = 1'b1;
            o_word = {WT_TRL, {(OW-3-EVCNT_W){1'b0}}, err_q, cnt_q};
            tq_pop = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (in_valid && !full) mem_q[wp_q[AW-1:0]] <= {in_ch, in_time};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         wp_q    <= '0;
         hp_q    <= '0;
         sp_q    <= '0;
         start_q <= '0;
         cnt_q   <= '0;
         evcnt_q <= '0;
         err_q   <= 1'b0;
      end else begin
         if (in_valid && !full) wp_q <= wp_q + 1'b1;
         if (drop) err_q <= 1'b1;
         else if (state_q == S_TRL && o_push) err_q <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (!mode_trig && o_push) hp_q <= hp_q + 1'b1;
               if (mode_trig && !tq_empty) begin
                  start_q <= tq_tag - latency;
                  cnt_q   <= '0;
                  state_q <= S_HDR;
               end
            end
            S_HDR: if (o_push) state_q <= S_PURGE;
            S_PURGE: begin
               if (buf_any && head_old) hp_q <= hp_q + 1'b1;
               else begin
                  sp_q    <= hp_q;
                  state_q <= S_SCAN;
               end
            end
            S_SCAN: begin
               if (scan_end) state_q <= S_TRL;
               else if (!scan_in) sp_q <= sp_q + 1'b1;
               else if (o_push) begin
                  sp_q  <= sp_q + 1'b1;
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            S_TRL: if (o_push) begin
               evcnt_q <= evcnt_q + 1'b1;
               state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   // R2
   data_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (wp_q == $past(wp_q)));
   // R6
   trig_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_valid |-> !tq_full);
   // R5
   win_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_SCAN && o_push) |-> ((o_word[TW-1 -: CW] - start_q) < win_len));
   // R4
   evcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_TRL && o_push) |=> (evcnt_q == $past(evcnt_q) + 1'b1));
   // R7
   trl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_TRL && o_push && !drop) |=> !err_q);
endmodule

// File: rtl/tdc_hit_buffer.sv
module tdc_hit_buffer
   import tdc_pkg::*;
#(
   parameter int NCH    = 8,
   parameter int TW     = TIME_W,
   parameter int CW     = COARSE_W,
   parameter int DDEPTH = 4,
   parameter int CDEPTH = 16,
   parameter int TDEPTH = 4,
   parameter int ODEPTH = 4,
   localparam int OW    = 2 + $clog2(NCH) + TW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_trig,
   input  logic [CW-1:0]     latency,
   input  logic [CW-1:0]     win_len,
   input  logic [NCH-1:0]    hit_valid,
   input  logic [NCH*TW-1:0] hit_time,
   input  logic              trig_valid,
   input  logic [CW-1:0]     trig_tag,
   output logic              out_valid,
   output logic [OW-1:0]     out_word
);
   localparam int CHW = $clog2(NCH);

   if (NCH < 2) begin : g_nch_chk
      $error("tdc_hit_buffer needs at least two channels");
   end
   if (CW >= TW) begin : g_cw_chk
      $error("tdc_hit_buffer coarse field must be narrower than the time word");
   end

   logic           m_valid, drop, c_full, o_push, o_full, o_empty;
   logic [CHW-1:0] m_ch;
   logic [TW-1:0]  m_time;
   logic [OW-1:0]  o_word;

   tdc_merge #(.NCH(NCH), .TW(TW), .DDEPTH(DDEPTH)) u_merge (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit_valid (hit_valid),
      .hit_time  (hit_time),
      .dst_full  (c_full),
      .m_valid   (m_valid),
      .m_ch      (m_ch),
      .m_time    (m_time),
      .drop      (drop)
   );

   tdc_match #(.NCH(NCH), .TW(TW), .CW(CW), .CDEPTH(CDEPTH),
               .TDEPTH(TDEPTH), .OW(OW)) u_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_trig  (mode_trig),
      .latency    (latency),
      .win_len    (win_len),
      .in_valid   (m_valid),
      .in_ch      (m_ch),
      .in_time    (m_time),
      .drop       (drop),
      .trig_valid (trig_valid),
      .trig_tag   (trig_tag),
      .o_full     (o_full),
      .full       (c_full),
      .o_push     (o_push),
      .o_word     (o_word)
   );

   tdc_fifo #(.W(OW), .DEPTH(ODEPTH)) u_outq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (o_push),
      .din   (o_word),
      .pop   (!o_empty),
      .dout  (out_word),
      .full  (o_full),
      .empty (o_empty)
   );

   assign out_valid = !o_empty;

   // R3
   out_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_word[OW-1 -: 2] != WT_NONE));
endmodule

// File: tb/tdc_hit_buffer_tb_top.sv
module tdc_hit_buffer_tb_top;
   localparam int NCH = 8;
   localparam int TW  = 21;
   localparam int CW  = 11;
   localparam int CAP = 16 + 4;
   localparam int OW  = 26;
   localparam logic [CW-1:0] LAT = 11'd100;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mode_trig = 1'b0;
   logic [CW-1:0]     latency = LAT;
   logic [CW-1:0]     win_len = 11'd20;
   logic [NCH-1:0]    hit_valid = '0;
   logic [NCH*TW-1:0] hit_time = '0;
   logic              trig_valid = 1'b0;
   logic [CW-1:0]     trig_tag = '0;
   logic              out_valid;
   logic [OW-1:0]     out_word;

   always #10 clk = ~clk;

   tdc_hit_buffer dut_i (
      .clk(clk), .rst_n(rst_n), .mode_trig(mode_trig), .latency(latency),
      .win_len(win_len), .hit_valid(hit_valid), .hit_time(hit_time),
      .trig_valid(trig_valid), .trig_tag(trig_tag),
      .out_valid(out_valid), .out_word(out_word)
   );

   typedef struct {
      logic [OW-1:0] w;
      string         tag;
   } exp_t;

   exp_t          expq[$];
   logic [23:0]   mq[$];
   int            checks = 0;
   int            fails  = 0;
   int            ev     = 0;
   logic          err_m  = 1'b0;
   logic          running = 1'b0;
   logic          done = 1'b0;

   task automatic check(input bit ok, input string tag,
                        input logic [OW-1:0] got, input logic [OW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   function automatic logic [TW-1:0] mk(input int coarse, input int fine);
      return {CW'(coarse), 10'(fine)};
   endfunction

   // reference model of one hit arriving
   task automatic send_hit(input int ch, input logic [TW-1:0] t);
      exp_t e;
      @(negedge clk);
      hit_valid = '0;
      hit_valid[ch] = 1'b1;
      hit_time[ch*TW +: TW] = t;
      if (!mode_trig) begin
         e.w = {2'b10, 3'(ch), t};
         e.tag = "R3";
         expq.push_back(e);
      end else if (mq.size() >= CAP) begin
         err_m = 1'b1;
      end else begin
         mq.push_back({3'(ch), t});
      end
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      hit_valid = '0;
      trig_valid = 1'b0;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic trig(input int tag, input string rtag);
      exp_t e;
      logic [CW-1:0] st, d;
      int cnt;
      @(negedge clk);
      hit_valid = '0;
      trig_valid = 1'b1;
      trig_tag = CW'(tag);
      st = CW'(tag) - latency;
      while (mq.size() > 0) begin
         d = mq[0][TW-1 -: CW] - st;
         if (d[CW-1]) void'(mq.pop_front());
         else break;
      end
      e.w = {2'b01, 12'd0, 12'(ev)};
      e.tag = "R4";
      expq.push_back(e);
      cnt = 0;
      foreach (mq[i]) begin
         d = mq[i][TW-1 -: CW] - st;
         if (d < win_len) begin
            e.w = {2'b10, mq[i]};
            e.tag = rtag;
            expq.push_back(e);
            cnt++;
         end
      end
      e.w = {2'b11, 11'd0, err_m, 12'(cnt)};
      e.tag = (err_m) ? "R8" : "R7";
      expq.push_back(e);
      err_m = 1'b0;
      ev++;
      @(negedge clk);
      trig_valid = 1'b0;
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (running && !done) begin
         if (out_valid) begin
            if (expq.size() == 0) begin
               check(1'b0, "R2 unexpected word", out_word, '0);
            end else begin
               exp_t e;
               e = expq.pop_front();
               check(out_word === e.w, e.tag, out_word, e.w);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         check(1'b0, "watchdog", '0, '0);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(out_valid === 1'b0, "R1 reset", {25'd0, out_valid}, '0);
      idle(4);
      check(out_valid === 1'b0, "R1 idle", {25'd0, out_valid}, '0);
      running = 1'b1;

      // non-triggered pass-through, R3
      for (int i = 0; i < NCH; i++) send_hit(i, mk(300 + 7 * i, 13 * i + 1));
      idle(3);
      send_hit(6, mk(2047, 1023));
      send_hit(2, mk(0, 0));
      idle(20);

      // triggered mode, overlapping windows R5 R6 R10
      mode_trig = 1'b1;
      idle(2);
      send_hit(1, mk(500, 5));
      send_hit(2, mk(510, 6));
      send_hit(3, mk(520, 7));
      send_hit(4, mk(530, 8));
      send_hit(6, mk(600, 9));
      idle(10);
      trig(620, "R5");
      trig(630, "R6");
      idle(40);
      win_len = 11'd5;
      trig(700, "R5");
      idle(40);
      trig(800, "R10");
      idle(40);

      // rollover R9
      win_len = 11'd12;
      send_hit(0, mk(2040, 1));
      send_hit(1, mk(2046, 2));
      send_hit(2, mk(3, 3));
      send_hit(3, mk(10, 4));
      idle(10);
      trig(96, "R9");
      idle(40);
      win_len = 11'd1;
      trig(120, "R10");
      idle(40);

      // derandomizer overflow R8
      win_len = 11'd8;
      for (int i = 0; i < 24; i++) send_hit(5, mk(1000 + i, i));
      idle(20);
      trig(1104, "R8");
      idle(60);
      trig(1112, "R6");
      idle(60);

      check(expq.size() == 0, "R7 frames complete", OW'(expq.size()), '0);
      if (!done) begin
         done = 1'b1;
         summary();
         $finish;
      end
   end
endmodule